// File: doc/BRIEF.md
# DSP Register Move and Immediate-Load Execute Unit

This unit is the execute step for three data-movement instructions of a 16-bit DSP that has a file of 32 sixteen-bit registers. When the execute strobe is high, it decodes the instruction word. For a register-to-register copy it reads the source register. For the long load it takes the immediate from the companion program word. For the short load it sign-extends an 8-bit field. The result is written to the destination register on the next rising clock edge.

The two accumulators each span three registers: a high part, a middle word and a low word. The status register holds a 40-bit mode flag. While that flag is set, any of the three instructions that targets an accumulator's middle word also rewrites that accumulator's high and low registers. An opcode the unit does not recognise changes nothing and raises an error strobe for one cycle. A separate read port lets the surrounding logic, or a bench, look at any register.

Top module: `dsp_regmove_unit`

## Requirements
- R1: The copy instruction has bits 15:10 equal to 000111. Bits 9:5 name the destination and bits 4:0 the source. The destination receives the source's value as it was before the edge, including when source and destination are the same register.
- R2: The long load has bits 15:5 equal to 00000000100 and bits 4:0 naming the destination. The destination receives `ext_word`.
- R3: The short load has bits 15:11 equal to 00001. It writes bits 7:0, sign-extended to 16 bits, into register 0x18 plus bits 10:8.
- R4: The mode flag is bit 14 of register 0x13, read before the instruction's own write. When the flag is 1 and the destination is 0x1e (accumulator 0 middle) or 0x1f (accumulator 1 middle), two more registers change on the same edge. The matching high register (0x10 or 0x11) becomes 0xFFFF if bit 15 of the written value is 1 and 0x0000 otherwise. The matching low register (0x1c or 0x1d) becomes 0x0000.
- R5: When the mode flag is 0, a write to 0x1e or 0x1f changes only that register.
- R6: The rule in R4 applies to the copy, the long load and the short load alike.
- R7: When `exec_valid` is high with an instruction matching none of the three encodings, `illegal` is 1 for the cycle after that edge and no register changes.
- R8: With `exec_valid` low, no register changes and `illegal` stays 0, whatever `instr` holds.
- R9: While `rst_n` is low, every register is reset to 0x0000 and `illegal` is 0.
- R10: `rd_data` shows, without a clock delay, the register selected by `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_valid | input | 1 | Executes `instr` on this edge |
| instr | input | 16 | Decoded instruction word |
| ext_word | input | 16 | Following program word (immediate for the long load) |
| rd_addr | input | 5 | Register index for the inspection port |
| rd_data | output | 16 | Contents of register `rd_addr` |
| illegal | output | 1 | One-cycle strobe for an unrecognised opcode |

## Verification
The loads use positive and negative immediates, and the copy uses distinct and identical source and destination registers. Each target register lies both inside and outside the accumulator range, which separates the plain write from the extension path. The same middle-word writes run with the mode flag clear and with it set, using values of both signs and low words preloaded with non-zero data, so a missing clear, a wrong sign or a wrong accumulator select each show up. After every instruction all 32 registers are compared against a model, which exposes any extra write, including after illegal opcodes and idle cycles carrying garbage instruction words.

// File: rtl/dsp_rm_pkg.sv
package dsp_rm_pkg;
    localparam int DW       = 16;
    localparam int NREG     = 32;
    localparam int AW       = $clog2(NREG);
    localparam int MODE_BIT = 14;

    localparam logic [AW-1:0] SR_IDX     = AW'(5'h13);
    localparam logic [AW-1:0] ACC_HI0    = AW'(5'h10);
    localparam logic [AW-1:0] ACC_LO0    = AW'(5'h1c);
    localparam logic [AW-1:0] ACC_MID0   = AW'(5'h1e);
    localparam logic [AW-1:0] SHORT_BASE = AW'(5'h18);

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_MOVE  = 2'd1,
        OP_LONG  = 2'd2,
        OP_SHORT = 2'd3
    } op_kind_e;

    typedef struct packed {
        op_kind_e          kind;
        logic [AW-1:0]     dst;
        logic [AW-1:0]     src;
        logic [DW-1:0]     imm;
    } dec_t;

    typedef struct packed {
        logic              we;
        logic [AW-1:0]     addr;
        logic [DW-1:0]     data;
        logic              ext;
        logic              ext_sel;
        logic              sign;
    } wr_t;
endpackage

// File: rtl/dsp_rm_decode.sv
module dsp_rm_decode
    import dsp_rm_pkg::*;
(
    input  logic [DW-1:0] instr,
    input  logic [DW-1:0] ext_word,
    output dec_t          dec
);
    always_comb begin
        dec = '0;
        if (instr[15:10] == 6'b000111) begin
            dec.kind = OP_MOVE;
            dec.dst  = instr[9:5];
            dec.src  = instr[4:0];
        end else if (instr[15:5] == 11'b00000000100) begin
            dec.kind = OP_LONG;
            dec.dst  = instr[4:0];
            dec.imm  = ext_word;
        end else if (instr[15:11] == 5'b00001) begin
            dec.kind = OP_SHORT;
            dec.dst  = SHORT_BASE + AW'(instr[10:8]);
            dec.imm  = {{(DW-8){instr[7]}}, instr[7:0]};
        end
    end
endmodule

// File: rtl/dsp_rm_acc_ext.sv
module dsp_rm_acc_ext
    import dsp_rm_pkg::*;
(
    input  logic          exec_valid,
    input  dec_t          dec,
    input  logic [DW-1:0] src_val,
    input  logic          mode40,
    output wr_t           wr
);
    logic [DW-1:0] val;
    logic          to_mid;

    always_comb begin
        val        = (dec.kind == OP_MOVE) ? src_val : dec.imm;
        to_mid     = (dec.dst == ACC_MID0) || (dec.dst == ACC_MID0 + AW'(1));
        wr         = '0;
        wr.we      = exec_valid && (dec.kind != OP_NONE);
        wr.addr    = dec.dst;
        wr.data    = val;
        wr.ext     = wr.we && mode40 && to_mid;
        wr.ext_sel = dec.dst[0];
        wr.sign    = val[DW-1];
    end
endmodule

// File: rtl/dsp_rm_regfile.sv
module dsp_rm_regfile
    import dsp_rm_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  wr_t                      wr,
    output logic [NREG-1:0][DW-1:0]  regs
);
    typedef struct packed {
        logic [NREG-1:0][DW-1:0] r;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (wr.we) begin
            rf_d.r[wr.addr] = wr.data;
        end
        if (wr.ext) begin
            rf_d.r[ACC_HI0 + AW'(wr.ext_sel)] = {DW{wr.sign}};
            rf_d.r[ACC_LO0 + AW'(wr.ext_sel)] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign regs = rf_q.r;
endmodule

// File: rtl/dsp_regmove_unit.sv
module dsp_regmove_unit
    import dsp_rm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exec_valid,
    input  logic [15:0]   instr,
    input  logic [15:0]   ext_word,
    input  logic [4:0]    rd_addr,
    output logic [15:0]   rd_data,
    output logic          illegal
);
    typedef struct packed {
        logic err;
    } top_st_t;

    dec_t                     dec;
    wr_t                      wr;
    logic [NREG-1:0][DW-1:0]  regs;
    logic [DW-1:0]            src_val;
    logic                     mode40;
    top_st_t                  st_d, st_q;

    dsp_rm_decode u_dec (
        .instr    (instr),
        .ext_word (ext_word),
        .dec      (dec)
    );

    assign src_val = regs[dec.src];
    assign mode40  = regs[SR_IDX][MODE_BIT];

    dsp_rm_acc_ext u_ext (
        .exec_valid (exec_valid),
        .dec        (dec),
        .src_val    (src_val),
        .mode40     (mode40),
        .wr         (wr)
    );

    dsp_rm_regfile u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr),
        .regs  (regs)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = exec_valid && (dec.kind == OP_NONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign illegal = st_q.err;
    assign rd_data = regs[rd_addr];
endmodule

// File: rtl/dsp_rm_checker.sv
module dsp_rm_checker (
    input logic              clk,
    input logic              rst_n,
    input logic              exec_valid,
    input logic [15:0]       instr,
    input logic [15:0]       ext_word,
    input logic              illegal,
    input logic [31:0][15:0] regs
);
    logic        is_mv, is_ll, is_sl, known, mode, dst_mid;
    logic [4:0]  dst_c;
    logic [15:0] mv_src;

    always_comb begin
        is_mv   = instr[15:10] == 6'b000111;
        is_ll   = instr[15:5] == 11'b00000000100;
        is_sl   = instr[15:11] == 5'b00001;
        known   = is_mv || is_ll || is_sl;
        dst_c   = is_mv ? instr[9:5] : (is_ll ? instr[4:0] : {2'b11, instr[10:8]});
        mode    = regs[5'h13][14];
        dst_mid = dst_c[4:1] == 4'hf;
        mv_src  = regs[instr[4:0]];
    end

    // R7: strobe only follows an executed unknown opcode
    a_r7_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> $past(exec_valid && !known));
    // R7: unknown opcode leaves every register alone
    a_r7_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> regs == $past(regs));
    // R8: idle cycles hold state
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(exec_valid) |-> (regs == $past(regs) && !illegal));
    // R1: copy delivers the old source value
    a_r1_copy: assert property (@(posedge clk) disable iff (!rst_n)
        $past(exec_valid && is_mv) |-> regs[$past(instr[9:5])] == $past(mv_src));
    // R2: long load writes the following word
    a_r2_long: assert property (@(posedge clk) disable iff (!rst_n)
        $past(exec_valid && is_ll) |-> regs[$past(instr[4:0])] == $past(ext_word));
    // R4: extension clears low word and fills high part with the sign
    a_r4_extend: assert property (@(posedge clk) disable iff (!rst_n)
        $past(exec_valid && known && mode && dst_mid) |->
            (regs[{4'b1110, $past(dst_c[0])}] == 16'h0000 &&
             regs[{4'b1000, $past(dst_c[0])}] == {16{regs[$past(dst_c)][15]}}));
    // R5: without the mode flag the low word survives
    a_r5_no_extend: assert property (@(posedge clk) disable iff (!rst_n)
        $past(exec_valid && known && !mode && dst_mid) |->
            regs[{4'b1110, $past(dst_c[0])}] == $past(regs[{4'b1110, dst_c[0]}]));
endmodule

bind dsp_regmove_unit dsp_rm_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .exec_valid (exec_valid),
    .instr      (instr),
    .ext_word   (ext_word),
    .illegal    (illegal),
    .regs       (regs)
);

// File: tb/sim_dsp_regmove_unit.sv
module sim_dsp_regmove_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] ext_word = '0;
    logic [4:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        illegal;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        bit          is_err;
        logic [4:0]  addr;
        logic [15:0] val;
        string       tag;
    } exp_t;

    exp_t        sbq[$];
    logic [15:0] mdl [32];

    always #5 clk = ~clk;

    dsp_regmove_unit u0 (
        .clk(clk), .rst_n(rst_n), .exec_valid(exec_valid), .instr(instr),
        .ext_word(ext_word), .rd_addr(rd_addr), .rd_data(rd_data), .illegal(illegal)
    );

    function automatic logic [15:0] op_ll(input logic [4:0] d);
        return {11'b00000000100, d};
    endfunction
    function automatic logic [15:0] op_sl(input logic [2:0] d, input logic [7:0] i);
        return {5'b00001, d, i};
    endfunction
    function automatic logic [15:0] op_mv(input logic [4:0] d, input logic [4:0] s);
        return {6'b000111, d, s};
    endfunction

    task automatic push_all(input bit err_exp, input string tag);
        exp_t e;
        e.is_err = 1; e.addr = '0; e.val = {15'd0, err_exp}; e.tag = tag;
        sbq.push_back(e);
        for (int i = 0; i < 32; i++) begin
            e.is_err = 0; e.addr = 5'(i); e.val = mdl[i]; e.tag = tag;
            sbq.push_back(e);
        end
    endtask

    // monitor: pops expected items and compares them with the ports
    task automatic drain();
        exp_t e;
        while (sbq.size() > 0) begin
            e = sbq.pop_front();
            n_run++;
            if (e.is_err) begin
                if (illegal !== e.val[0]) begin
                    n_fail++;
                    $display("FAIL %s illegal: got %0b expected %0b", e.tag, illegal, e.val[0]);
                end
            end else begin
                rd_addr = e.addr;
                #1;
                if (rd_data !== e.val) begin
                    n_fail++;
                    $display("FAIL %s reg 0x%02h: got 0x%04h expected 0x%04h",
                             e.tag, e.addr, rd_data, e.val);
                end
            end
        end
    endtask

    // driver: updates the model from the requirements, executes, queues expectations
    task automatic run(input logic [15:0] ins, input logic [15:0] ew, input string tag);
        bit          kn = 1;
        logic [4:0]  d;
        logic [15:0] v;
        logic [15:0] nm [32];
        nm = mdl;
        if (ins[15:10] == 6'b000111) begin d = ins[9:5]; v = mdl[ins[4:0]]; end
        else if (ins[15:5] == 11'b00000000100) begin d = ins[4:0]; v = ew; end
        else if (ins[15:11] == 5'b00001) begin d = {2'b11, ins[10:8]}; v = {{8{ins[7]}}, ins[7:0]}; end
        else begin kn = 0; d = '0; v = '0; end
        if (kn) begin
            nm[d] = v;
            if (mdl[5'h13][14] && d[4:1] == 4'hf) begin
                nm[{4'b1000, d[0]}] = {16{v[15]}};
                nm[{4'b1110, d[0]}] = 16'h0000;
            end
        end
        @(negedge clk);
        instr = ins; ext_word = ew; exec_valid = 1'b1;
        @(negedge clk);
        exec_valid = 1'b0; instr = 16'h5a5a ^ ins;
        mdl = nm;
        push_all(!kn, tag);
        drain();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) mdl[i] = 16'h0000;
        instr = 16'h1234; exec_valid = 1'b1;
        repeat (3) @(negedge clk);
        exec_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        push_all(0, "R9 reset");
        drain();

        run(op_ll(5'h03), 16'hA5A5, "R2 R10");
        run(op_ll(5'h1c), 16'h1234, "R2");
        run(op_ll(5'h1d), 16'h5678, "R2");
        run(op_ll(5'h10), 16'h00AB, "R2");
        run(op_sl(3'd0, 8'h7f), 16'hFFFF, "R3");
        run(op_sl(3'd1, 8'h80), 16'h0000, "R3");
        run(op_sl(3'd3, 8'hff), 16'h0000, "R3");
        run(op_mv(5'h05, 5'h03), 16'h0000, "R1");
        run(op_mv(5'h03, 5'h19), 16'h0000, "R1");
        run(op_mv(5'h07, 5'h07), 16'h0000, "R1");
        run(op_ll(5'h1e), 16'h8000, "R5");
        run(op_sl(3'd7, 8'h90), 16'h0000, "R5");

        run(op_ll(5'h13), 16'h4000, "R4 mode on");
        run(op_ll(5'h1e), 16'h8001, "R4");
        run(op_ll(5'h1d), 16'h7777, "R4");
        run(op_ll(5'h11), 16'h4444, "R4");
        run(op_sl(3'd7, 8'h05), 16'h0000, "R6 short");
        run(op_ll(5'h1c), 16'h2222, "R6");
        run(op_mv(5'h1e, 5'h19), 16'h0000, "R6 copy");
        run(op_ll(5'h1d), 16'h3333, "R6");
        run(op_mv(5'h1f, 5'h03), 16'h0000, "R6 copy");

        run(16'hFFFF, 16'h0000, "R7");
        run(16'h0000, 16'h1111, "R7");
        run(16'h1300, 16'h0000, "R7");

        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            instr = op_ll(5'(k)); ext_word = 16'hDEAD;
        end
        @(negedge clk);
        push_all(0, "R8 idle");
        drain();

        run(op_ll(5'h13), 16'h0000, "R5 mode off");
        run(op_ll(5'h1c), 16'h0F0F, "R5");
        run(op_mv(5'h1f, 5'h19), 16'h0000, "R5");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule